// File: doc/BRIEF.md
# SDRAM Refresh Request Controller

This block decides when an external SDRAM must be refreshed and passes that decision to a bus sequencer. A programmable timer sets the pace. It has a prescaler, an up-counter and a compare value. Each time the counter reaches the compare value, the counter wraps to zero, a sticky match flag is set and a one-cycle match event is produced. The timer runs whether refresh is enabled or not, so it can also serve as an ordinary interval timer.

Two control bits select the behaviour: a refresh enable and a refresh mode.
- In auto mode, every match latches an auto-refresh request. The request is held until the sequencer acknowledges it. While it is pending and the external bus is busy, the block also asks the sequencer to abort the current bus cycle.
- In self-refresh mode, the block waits until the bus is idle. It then issues a single self-refresh entry request and records that the memory is in self-refresh.
- Clearing either control bit while the memory is in self-refresh produces a one-cycle exit request. It also restarts the timer from zero.

Top module: `sdram_refresh_ctrl`

## Requirements
- R1: After reset the control register reads 0, the counter reads 0, the compare value reads all ones, the match flag reads 0, and every request output is low.
- R2: While the enable bit (bit 2 of register 0) is 0, neither `ar_req` nor `sr_entry_req` is ever asserted, even though timer matches still occur.
- R3: The counter (register 1) advances once every PRESCALE clocks. A tick that finds the counter equal to the compare value (register 2) wraps it to 0, pulses `timer_match` for one cycle and sets the match flag (register 3, bit 0). Any write to register 3 clears the flag.
- R4: With enable 1 and mode (bit 1 of register 0) at 0, `ar_req` rises in the cycle after a `timer_match`. Successive requests are spaced (compare+1)*PRESCALE clocks apart.
- R5: A pending `ar_req` stays high until `ref_ack` is seen and drops in the following cycle. If `ref_ack` and `timer_match` fall in the same cycle, the request stays high for the new period.
- R6: `bus_abort` is high exactly while `ar_req` is high and `bus_busy` is high.
- R7: With enable 1 and mode 1, `sr_entry_req` is withheld while `bus_busy` is high. After `bus_busy` falls it pulses for exactly one cycle, in the cycle after the first idle cycle, and `in_self_refresh` goes high together with it.
- R8: While `in_self_refresh` is high, timer matches raise no `ar_req`.
- R9: Clearing the enable or mode bit while in self-refresh gives a one-cycle `sr_exit_req` in the cycle after the write takes effect. In that same cycle `in_self_refresh` is low and the counter reads 0, and auto refresh then resumes.
- R10: Bit 0 of the control register always reads 0 whatever is written to it.
- R11: The mode bit has no effect while the enable bit is 0: with mode 1 and enable 0, no self-refresh entry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 counter, 2 compare, 3 match flag |
| cfg_wdata | input | REG_W | Register write data |
| cfg_rdata | output | REG_W | Register read data for `cfg_addr` (combinational) |
| bus_busy | input | 1 | An external bus cycle is in progress |
| ref_ack | input | 1 | Sequencer has accepted the pending auto-refresh |
| ar_req | output | 1 | Auto-refresh request, held until acknowledged |
| bus_abort | output | 1 | Request to end the current bus cycle early |
| sr_entry_req | output | 1 | One-cycle self-refresh entry request |
| sr_exit_req | output | 1 | One-cycle self-refresh exit request |
| in_self_refresh | output | 1 | Memory is in self-refresh |
| timer_match | output | 1 | One-cycle event when the counter wraps at the compare value |

## Verification
The case of interest is a timer match that lands in the same cycle as the sequencer's acknowledge of an earlier, still pending auto-refresh. The bench leaves a request unacknowledged. It watches `timer_match` at the falling clock edge and raises `ref_ack` in exactly that cycle, so both are seen at one rising edge. It then judges the outcome: `ar_req` must still be high afterwards, since a new period began, and must drop only after a second, separate acknowledge.

// File: rtl/sdr_refresh_pkg.sv
package sdr_refresh_pkg;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_COUNT = 2'd1,
    REG_CMP   = 2'd2,
    REG_FLAG  = 2'd3
  } reg_sel_e;

  localparam int CTRL_EN_BIT   = 2;
  localparam int CTRL_MODE_BIT = 1;

  // counter value after a tick: wrap at compare, else increment
  function automatic logic [31:0] tick_next(input logic [31:0] cur, input logic [31:0] lim);
    return (cur == lim) ? 32'd0 : cur + 32'd1;
  endfunction

endpackage

// File: rtl/ref_prescaler.sv
module ref_prescaler #(
  parameter int PRESCALE = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PS_W-1:0] LAST = PS_W'(PRESCALE - 1);

  logic [PS_W-1:0] div_q;

  assign tick = (div_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/ref_timer.sv
module ref_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic             cnt_we,
  input  logic             cmp_we,
  input  logic             flag_clr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cmp,
  output logic             flag,
  output logic             match
);
  import sdr_refresh_pkg::*;

  logic [31:0] nxt32;

  assign match = tick && (cnt == cmp);
  assign nxt32 = tick_next(32'(cnt), 32'(cmp));

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (cnt_we) cnt <= wdata;
    else if (tick)   cnt <= nxt32[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cmp <= '1;
    else if (cmp_we) cmp <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        flag <= 1'b0;
    else if (match)    flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end
endmodule

// File: rtl/ref_arbiter.sv
module ref_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic mode,
  input  logic match,
  input  logic ack,
  input  logic bus_busy,
  output logic ar_req,
  output logic abort,
  output logic sr_entry,
  output logic sr_exit,
  output logic in_sr,
  output logic timer_clr
);
  logic auto_on, self_on, enter_now, leave_now;

  assign auto_on   = en && !mode;
  assign self_on   = en && mode;
  assign enter_now = self_on && !in_sr && !bus_busy;
  assign leave_now = in_sr && !self_on;
  assign timer_clr = leave_now;
  assign abort     = ar_req && bus_busy;

  // pending auto request: new match wins over a same-cycle acknowledge
  always_ff @(posedge clk) begin
    if (!rst_n)                ar_req <= 1'b0;
    else if (!auto_on || in_sr) ar_req <= 1'b0;
    else if (match)            ar_req <= 1'b1;
    else if (ack)              ar_req <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_sr    <= 1'b0;
      sr_entry <= 1'b0;
      sr_exit  <= 1'b0;
    end else begin
      sr_entry <= enter_now;
      sr_exit  <= leave_now;
      if (enter_now)      in_sr <= 1'b1;
      else if (leave_now) in_sr <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_refresh_ctrl.sv
module sdram_refresh_ctrl #(
  parameter int REG_W    = 16,
  parameter int CNT_W    = 8,
  parameter int PRESCALE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             bus_busy,
  input  logic             ref_ack,
  output logic             ar_req,
  output logic             bus_abort,
  output logic             sr_entry_req,
  output logic             sr_exit_req,
  output logic             in_self_refresh,
  output logic             timer_match
);
  import sdr_refresh_pkg::*;

  logic             ref_en, ref_mode;
  logic             ctrl_wr, cnt_wr, cmp_wr, flag_wr;
  logic             tick, timer_clr, match_flag;
  logic [CNT_W-1:0] cnt_q, cmp_q;

  assign ctrl_wr = cfg_we && (cfg_addr == REG_CTRL);
  assign cnt_wr  = cfg_we && (cfg_addr == REG_COUNT);
  assign cmp_wr  = cfg_we && (cfg_addr == REG_CMP);
  assign flag_wr = cfg_we && (cfg_addr == REG_FLAG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_en   <= 1'b0;
      ref_mode <= 1'b0;
    end else if (ctrl_wr) begin
      ref_en   <= cfg_wdata[CTRL_EN_BIT];
      ref_mode <= cfg_wdata[CTRL_MODE_BIT];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      REG_CTRL: begin
        cfg_rdata[CTRL_EN_BIT]   = ref_en;
        cfg_rdata[CTRL_MODE_BIT] = ref_mode;
      end
      REG_COUNT: cfg_rdata[CNT_W-1:0] = cnt_q;
      REG_CMP:   cfg_rdata[CNT_W-1:0] = cmp_q;
      default:   cfg_rdata[0] = match_flag;
    endcase
  end

  ref_prescaler #(.PRESCALE(PRESCALE)) u_psc (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  ref_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(timer_clr),
    .cnt_we(cnt_wr), .cmp_we(cmp_wr), .flag_clr(flag_wr),
    .wdata(cfg_wdata[CNT_W-1:0]), .cnt(cnt_q), .cmp(cmp_q),
    .flag(match_flag), .match(timer_match)
  );

  ref_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .en(ref_en), .mode(ref_mode),
    .match(timer_match), .ack(ref_ack), .bus_busy(bus_busy),
    .ar_req(ar_req), .abort(bus_abort), .sr_entry(sr_entry_req),
    .sr_exit(sr_exit_req), .in_sr(in_self_refresh), .timer_clr(timer_clr)
  );
endmodule

// File: rtl/sdram_refresh_chk.sv
module sdram_refresh_chk (
  input logic clk,
  input logic rst_n,
  input logic ref_en,
  input logic ref_mode,
  input logic ctrl_wr,
  input logic timer_match,
  input logic ar_req,
  input logic ref_ack,
  input logic bus_busy,
  input logic sr_entry_req,
  input logic sr_exit_req,
  input logic in_sr
);
  assert_disabled_no_auto_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_en |=> !ar_req);
  assert_disabled_no_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_en |=> !sr_entry_req);
  assert_req_after_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ar_req) |-> $past(timer_match));
  assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_req && !ref_ack && ref_en && !ref_mode && !ctrl_wr && !in_sr) |=> ar_req);
  assert_entry_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sr_entry_req |-> $past(!bus_busy));
  assert_entry_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sr_entry_req |=> !sr_entry_req);
  assert_no_auto_in_sr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_sr |-> !ar_req);
  assert_exit_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit_req |=> !sr_exit_req);
endmodule

bind sdram_refresh_ctrl sdram_refresh_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .ref_mode(ref_mode),
  .ctrl_wr(ctrl_wr), .timer_match(timer_match), .ar_req(ar_req),
  .ref_ack(ref_ack), .bus_busy(bus_busy), .sr_entry_req(sr_entry_req),
  .sr_exit_req(sr_exit_req), .in_sr(in_self_refresh)
);

// File: tb/tb_sdram_refresh_ctrl.sv
module tb_sdram_refresh_ctrl;
  localparam int REG_W = 16;
  localparam int PRESCALE = 4;
  localparam int CMPV = 3;
  localparam int PERIOD = (CMPV + 1) * PRESCALE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [REG_W-1:0] cfg_wdata = '0;
  logic [REG_W-1:0] cfg_rdata;
  logic bus_busy = 1'b0, ref_ack = 1'b0;
  logic ar_req, bus_abort, sr_entry_req, sr_exit_req, in_self_refresh, timer_match;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_refresh_ctrl #(.REG_W(REG_W), .CNT_W(8), .PRESCALE(PRESCALE)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_busy(bus_busy),
    .ref_ack(ref_ack), .ar_req(ar_req), .bus_abort(bus_abort),
    .sr_entry_req(sr_entry_req), .sr_exit_req(sr_exit_req),
    .in_self_refresh(in_self_refresh), .timer_match(timer_match)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = REG_W'(d);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    cfg_addr = a; #1;
    v = int'(cfg_rdata);
  endtask

  task automatic t_reset();
    int v;
    @(negedge clk);
    rd(2'd0, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(2'd1, v); chk(v == 0, "R1 count", v, 0);
    rd(2'd2, v); chk(v == 255, "R1 compare", v, 255);
    rd(2'd3, v); chk(v == 0, "R1 flag", v, 0);
    chk(!ar_req && !bus_abort && !sr_entry_req && !sr_exit_req && !in_self_refresh,
        "R1 outputs", int'(ar_req), 0);
  endtask

  task automatic t_ctrl_bits();
    int v;
    wr(2'd0, 7); @(negedge clk); rd(2'd0, v);
    chk(v == 6, "R10 bit0 reads zero", v, 6);
    wr(2'd0, 1); @(negedge clk); rd(2'd0, v);
    chk(v == 0, "R10 only bit0 written", v, 0);
  endtask

  task automatic t_interval();
    int last = -1, seen = 0, badgap = 0, req_seen = 0, v;
    wr(2'd2, CMPV); wr(2'd1, 0);
    for (int i = 0; i < 6 * PERIOD; i++) begin
      @(negedge clk);
      if (ar_req || sr_entry_req) req_seen++;
      if (timer_match) begin
        if (last >= 0 && (cyc - last) != PERIOD) badgap++;
        last = cyc; seen++;
      end
    end
    chk(seen >= 5, "R3 matches occur", seen, 5);
    chk(badgap == 0, "R3 match spacing", badgap, 0);
    chk(req_seen == 0, "R2 no request while disabled", req_seen, 0);
    rd(2'd3, v); chk(v == 1, "R3 flag set", v, 1);
    while (!timer_match) @(negedge clk);
    @(negedge clk);
    wr(2'd3, 0); @(negedge clk); rd(2'd3, v);
    chk(v == 0, "R3 flag cleared", v, 0);
  endtask

  task automatic t_auto();
    bit pm = 0; int rise1 = 0, n = 0;
    wr(2'd0, 4);
    pm = timer_match;
    for (int i = 0; i < 4 * PERIOD && !ar_req; i++) begin
      @(negedge clk);
      if (ar_req) break;
      pm = timer_match;
    end
    chk(ar_req, "R4 request raised", int'(ar_req), 1);
    chk(pm, "R4 request follows match", int'(pm), 1);
    rise1 = cyc;
    chk(!bus_abort, "R6 no abort when idle", int'(bus_abort), 0);
    bus_busy = 1'b1; #1;
    chk(bus_abort, "R6 abort when busy", int'(bus_abort), 1);
    ref_ack = 1'b1;
    @(negedge clk); ref_ack = 1'b0;
    chk(!ar_req, "R5 cleared by ack", int'(ar_req), 1'b0);
    chk(!bus_abort, "R6 abort drops with request", int'(bus_abort), 0);
    bus_busy = 1'b0;
    while (!ar_req && n < 4 * PERIOD) begin @(negedge clk); n++; end
    chk((cyc - rise1) == PERIOD, "R4 request spacing", cyc - rise1, PERIOD);
  endtask

  task automatic t_collide();
    int n = 0;
    while (!timer_match && n < 4 * PERIOD) begin @(negedge clk); n++; end
    chk(ar_req && timer_match, "R5 pending at match", int'(ar_req), 1);
    ref_ack = 1'b1;
    @(negedge clk); ref_ack = 1'b0;
    chk(ar_req, "R5 match beats ack", int'(ar_req), 1);
    ref_ack = 1'b1;
    @(negedge clk); ref_ack = 1'b0;
    chk(!ar_req, "R5 second ack clears", int'(ar_req), 0);
  endtask

  task automatic t_self();
    int e = 0;
    wr(2'd0, 2);
    for (int i = 0; i < 3 * PERIOD; i++) begin
      @(negedge clk); if (sr_entry_req || in_self_refresh) e++;
    end
    chk(e == 0, "R11 mode ignored when disabled", e, 0);
    bus_busy = 1'b1;
    wr(2'd0, 6);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); if (sr_entry_req || in_self_refresh) e++;
    end
    chk(e == 0, "R7 waits for bus idle", e, 0);
    bus_busy = 1'b0;
    @(negedge clk);
    chk(sr_entry_req && in_self_refresh, "R7 entry after idle", int'(sr_entry_req), 1);
    @(negedge clk);
    chk(!sr_entry_req && in_self_refresh, "R7 single entry pulse", int'(sr_entry_req), 0);
  endtask

  task automatic t_in_sr();
    int m = 0, r = 0;
    for (int i = 0; i < 3 * PERIOD; i++) begin
      @(negedge clk);
      if (timer_match) m++;
      if (ar_req) r++;
    end
    chk(m >= 2, "R8 timer still runs", m, 2);
    chk(r == 0, "R8 matches ignored in self-refresh", r, 0);
  endtask

  task automatic t_exit();
    int v, n = 0;
    wr(2'd0, 4);
    cfg_addr = 2'd1;
    @(negedge clk);
    chk(!sr_exit_req, "R9 exit not early", int'(sr_exit_req), 0);
    @(negedge clk);
    rd(2'd1, v);
    chk(sr_exit_req, "R9 exit pulse", int'(sr_exit_req), 1);
    chk(!in_self_refresh, "R9 left self-refresh", int'(in_self_refresh), 0);
    chk(v == 0, "R9 counter cleared", v, 0);
    @(negedge clk);
    chk(!sr_exit_req, "R9 exit single pulse", int'(sr_exit_req), 0);
    while (!ar_req && n < 4 * PERIOD) begin @(negedge clk); n++; end
    chk(ar_req, "R9 auto refresh resumes", int'(ar_req), 1);
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_ctrl_bits();
    t_interval();
    t_auto();
    t_collide();
    t_self();
    t_in_sr();
    t_exit();
    done = 1;
    finish_up();
  end
endmodule